// File: doc/BRIEF.md
# Bidirectional Pin Port with Emulation Redirect

This block controls a bank of general-purpose pins through two registers on a simple peripheral bus. Offset 0 holds the pin output value, and offset 1 holds the per-pin direction. For each pin, a direction bit of 1 enables the pad driver, which then drives the value held in the output register. A direction bit of 0 leaves the pad at high impedance, and its level is read back as an input.

Each pad input passes through a chain of synchronizer flops clocked by the bus clock before it reaches the read path. A read of offset 0 returns, bit by bit, either the latched output value or the synchronized pad level, depending on the direction bit.

When the emulation input is high, register access is redirected:
- Reads of either register return the word presented on an external bus input, not the local contents.
- Writes still update the local register, and are also mirrored to the external bus in the same cycle. The mirror carries the address, the write data and a single-cycle strobe.

Top module: `gpio_emu_port`

## Requirements
- R1: After reset the direction register and the output register are all zeros, so `pad_oe` and `pad_out` are 0 and a read of offset 1 returns 0.
- R2: Outside emulation, a write at offset 1 sets the direction register, and a later read of offset 1 returns the written value.
- R3: `pad_oe` equals the direction register bit for bit, and `pad_out` equals the output register written at offset 0, from the cycle after the write.
- R4: Outside emulation, a read of offset 0 returns the output register bit for pins whose direction bit is 1, and the synchronized pad level for pins whose direction bit is 0.
- R5: A pad input change becomes visible on an offset-0 read exactly two clock edges after it is applied, and not after only one.
- R6: While `emu_mode` is 1, a read of offset 0 or offset 1 returns `ext_rdata`.
- R7: While `emu_mode` is 1, a write updates the local register, and in the same cycle raises `ext_we` for that single cycle with `ext_addr` and `ext_wdata` equal to the bus address and data.
- R8: `ext_we` stays 0 whenever `emu_mode` is 0 or no write is in progress.
- R9: `bus_ready` is 1 in every cycle in which `bus_sel` is 1, giving single-cycle reads and writes.
- R10: Outside emulation, a write to an offset other than 0 or 1 changes neither register, and a read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid while selected |
| bus_ready | output | 1 | Access completes this cycle |
| emu_mode | input | 1 | Emulation redirect enable |
| ext_rdata | input | WIDTH | External bus read word |
| ext_we | output | 1 | Mirrored write strobe |
| ext_addr | output | ADDR_W | Mirrored write address |
| ext_wdata | output | WIDTH | Mirrored write data |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |

## Verification
The hardest case to reach from the ports is the exact synchronizer latency. The bench must show that a pad change is absent after one edge and present after the second. To do so, it changes `pad_in` on a falling edge and issues back-to-back reads on the next two falling edges.

A second subtle case is an emulation-mode write. There, the read path hides the local register behind `ext_rdata`. The bench therefore observes the local update through `pad_oe`, and also reads the register again after leaving emulation.

// File: rtl/gpio_emu_pkg.sv
package gpio_emu_pkg;
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_DIR  = 1;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_DIR  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_emu_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output reg_sel_e          hit,
   output logic [WIDTH-1:0]  out_q,
   output logic [WIDTH-1:0]  dir_q
);
   always_comb begin
      hit = SEL_NONE;
      if (bus_sel) begin
         if (bus_addr == ADDR_W'(OFS_DATA))     hit = SEL_DATA;
         else if (bus_addr == ADDR_W'(OFS_DIR)) hit = SEL_DIR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
      end else if (bus_wr) begin
         if (hit == SEL_DATA) out_q <= bus_wdata;
         if (hit == SEL_DIR)  dir_q <= bus_wdata;
      end
   end
endmodule

// File: rtl/gpio_emu_port.sv
module gpio_emu_port
   import gpio_emu_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic              bus_ready,
   input  logic              emu_mode,
   input  logic [WIDTH-1:0]  ext_rdata,
   output logic              ext_we,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [WIDTH-1:0]  ext_wdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe
);
   generate
      if (WIDTH < 1) begin : g_bad_w
         $error("gpio_emu_port: WIDTH must be positive");
      end
      if (ADDR_W < 1) begin : g_bad_a
         $error("gpio_emu_port: ADDR_W must be positive");
      end
   endgenerate

   reg_sel_e         hit;
   logic [WIDTH-1:0] out_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] data_view;

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .hit       (hit),
      .out_q     (out_q),
      .dir_q     (dir_q)
   );

   // per-pin choice between driven value and sampled level
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign data_view[i] = dir_q[i] ? out_q[i] : pin_sync[i];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (emu_mode) begin
            bus_rdata = ext_rdata;
         end else begin
            case (hit)
               SEL_DATA: bus_rdata = data_view;
               SEL_DIR:  bus_rdata = dir_q;
               default:  bus_rdata = '0;
            endcase
         end
      end
   end

   assign bus_ready = bus_sel;
   assign ext_we    = bus_sel & bus_wr & emu_mode;
   assign ext_addr  = bus_addr;
   assign ext_wdata = bus_wdata;
   assign pad_out   = out_q;
   assign pad_oe    = dir_q;
endmodule

// File: rtl/gpio_emu_port_chk.sv
module gpio_emu_port_chk #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic              bus_ready,
   input logic              emu_mode,
   input logic [WIDTH-1:0]  ext_rdata,
   input logic              ext_we,
   input logic [WIDTH-1:0]  ext_wdata,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_oe
);
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && pad_out == '0));

   a_r3_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(1)) |=> pad_oe == $past(bus_wdata));

   a_r6_emu_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && emu_mode) |-> bus_rdata == ext_rdata);

   a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && emu_mode) |-> (ext_we && ext_wdata == bus_wdata));

   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!emu_mode || !bus_sel || !bus_wr) |-> !ext_we);

   a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel |-> bus_ready);

   a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr > ADDR_W'(1)) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_emu_port gpio_emu_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_emu_port_tb_top.sv
module gpio_emu_port_tb_top;
   localparam int W = 8;
   localparam int A = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0;
   logic         bus_wr = 1'b0;
   logic [A-1:0] bus_addr = '0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         bus_ready;
   logic         emu_mode = 1'b0;
   logic [W-1:0] ext_rdata = '0;
   logic         ext_we;
   logic [A-1:0] ext_addr;
   logic [W-1:0] ext_wdata;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_emu_port #(.WIDTH(W), .ADDR_W(A)) dut_i (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // call at a falling edge; returns at the next falling edge
   task automatic bus_write(logic [A-1:0] a, logic [W-1:0] d, bit mirror);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      #1;
      check("R9 ready on write", 32'(bus_ready), 1);
      if (mirror) begin
         check("R7 ext_we", 32'(ext_we), 1);
         check("R7 ext_addr", 32'(ext_addr), 32'(a));
         check("R7 ext_wdata", 32'(ext_wdata), 32'(d));
      end else begin
         check("R8 no mirror", 32'(ext_we), 0);
      end
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      #1;
      check("R8 strobe single cycle", 32'(ext_we), 0);
   endtask

   task automatic bus_read(logic [A-1:0] a, output logic [W-1:0] d);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1;
      check("R9 ready on read", 32'(bus_ready), 1);
      d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic t_reset();
      logic [W-1:0] d;
      check("R1 pad_oe", 32'(pad_oe), 0);
      check("R1 pad_out", 32'(pad_out), 0);
      bus_read(1, d);
      check("R1 dir read", 32'(d), 0);
   endtask

   task automatic t_dir_and_data();
      logic [W-1:0] d;
      bus_write(1, 8'hA5, 0);
      check("R3 pad_oe", 32'(pad_oe), 32'hA5);
      bus_read(1, d);
      check("R2 dir readback", 32'(d), 32'hA5);
      bus_write(0, 8'h3C, 0);
      check("R3 pad_out", 32'(pad_out), 32'h3C);
      pad_in = 8'h0F;
      repeat (3) @(negedge clk);
      bus_read(0, d);
      check("R4 mixed read", 32'(d), 32'((8'hA5 & 8'h3C) | (~8'hA5 & 8'h0F)));
      bus_write(1, 8'hFF, 0);
      bus_read(0, d);
      check("R4 all outputs", 32'(d), 32'h3C);
   endtask

   task automatic t_sync_latency();
      logic [W-1:0] d;
      bus_write(1, 8'h00, 0);
      pad_in = 8'h00;
      repeat (3) @(negedge clk);
      pad_in = 8'hC3;
      @(negedge clk);
      bus_read(0, d);
      check("R5 not after one edge", 32'(d), 32'h00);
      bus_read(0, d);
      check("R5 visible after two edges", 32'(d), 32'hC3);
   endtask

   task automatic t_emulation();
      logic [W-1:0] d;
      emu_mode = 1; ext_rdata = 8'h96;
      bus_read(1, d);
      check("R6 emu dir read", 32'(d), 32'h96);
      bus_read(0, d);
      check("R6 emu data read", 32'(d), 32'h96);
      bus_write(1, 8'h5A, 1);
      check("R7 local dir updated", 32'(pad_oe), 32'h5A);
      bus_write(0, 8'h81, 1);
      check("R7 local data updated", 32'(pad_out), 32'h81);
      emu_mode = 0;
      bus_read(1, d);
      check("R7 dir after emu", 32'(d), 32'h5A);
   endtask

   task automatic t_unmapped();
      logic [W-1:0] d;
      bus_write(2, 8'hFF, 0);
      check("R10 dir untouched", 32'(pad_oe), 32'h5A);
      check("R10 data untouched", 32'(pad_out), 32'h81);
      bus_write(4'hF, 8'h00, 0);
      check("R10 dir untouched hi", 32'(pad_oe), 32'h5A);
      bus_read(2, d);
      check("R10 unmapped read", 32'(d), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_dir_and_data();
      t_sync_latency();
      t_emulation();
      t_unmapped();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule